// File: doc/BRIEF.md
# SD Host Clock and Reset Control Register

This block is the clock and reset control word of an SD/MMC host controller. Software reaches it through a one-word write strobe and a continuously driven read-back. The word turns on an internal clock and reports when that clock has settled. It selects a divisor that derives the card clock from the base clock. It gates the card clock onto the output, and it holds a data-timeout code that goes to the data path. Three write-one bits request soft resets of the whole controller, of the command path, or of the data path. Each of these bits clears itself once its reset has run.

The register enforces the bring-up order in hardware. The card-clock gate cannot be opened until the internal clock reports stable. A new divisor is refused while the gate is open or while the command or data line is busy. A reset bit keeps reading 1 from the first read after the write until the reset has finished, so software can poll it without seeing a false early completion.

Top module: `sd_clkrst_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 0, `card_clk`, `cmd_rst`, `dat_rst` and `rst_busy` are low, and `data_tmo` is 0.
- R2: The field positions in `rd_data` and `wr_data` are:
  - bit 0: clock enable.
  - bit 1: stable flag, read-only.
  - bit 2: card-clock gate.
  - bits 15:6: divisor.
  - bits 19:16: timeout code. It is writable and appears on `data_tmo`.
  - bit 24: reset the whole controller.
  - bit 25: reset the command path.
  - bit 26: reset the data path.

  Bits 31:27, 23:20 and 5:3 read 0 whatever is written to them. Writing bit 1 has no effect.
- R3: The stable flag reads 1 from the STABLE_CYCLES-th clock edge after the edge that wrote the enable to 1. It reads 0 right after an edge that writes the enable to 0.
- R4: A write of 1 to the gate takes effect only if the stable flag is already 1 in the cycle of the write and the same write keeps the enable at 1. Otherwise the gate reads 0.
- R5: A write to the divisor field is ignored while the gate is 1, and ignored while `cmd_busy` or `dat_busy` is high.
- R6: With divisor N of 2 or more, `card_clk` starts high on the first clock edge after the edge that opens the gate. It then repeats a period of N base-clock cycles: high for floor(N/2) cycles, low for the rest.
- R7: With a divisor of 0 or 1, `card_clk` follows the base clock while the gate is open.
- R8: `card_clk` is low from the second edge after the gate is closed. The divider picks up the divisor only while the gate is closed.
- R9: After a write of 1 to bit 25 or 26, that bit reads 1 on the next RST_CYCLES reads and 0 after that. During that time `cmd_rst` (bit 25) or `dat_rst` (bit 26) is high and the other reset output stays low.
- R10: A write of 1 to bit 24 does three things. It raises both `cmd_rst` and `dat_rst` for RST_CYCLES cycles. It clears the enable, the gate and the divisor. Writes to those three fields are ignored until bit 24 reads 0 again.
- R11: `rst_busy` is high exactly while any reset bit reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Value written |
| rd_data | output | 32 | Current control word |
| cmd_busy | input | 1 | Command line in use |
| dat_busy | input | 1 | Data lines in use |
| data_tmo | output | 4 | Timeout code for the data path |
| card_clk | output | 1 | Divided and gated card clock |
| cmd_rst | output | 1 | Command-path reset |
| dat_rst | output | 1 | Data-path reset |
| rst_busy | output | 1 | A soft reset is running |

## Verification
The bench sweeps every divisor from 0 to 12 and compares each base-clock sample of `card_clk` with the expected phase. This catches an off-by-one in the counter wrap, a wrong high time for odd divisors, and a first pulse that comes one edge late. It counts the stable flag edge by edge and tries to open the gate too early. A design that opened the gate without the handshake, or that raised the flag one cycle early or late, would fail here. The bench tries to change the divisor while the gate is open and while each busy line is high; a design with the lockout missing would read back the new divisor. Each reset bit is polled from the very first read after its write, so a bit that cleared too soon, drove the wrong reset output, or let the enable be written back during a whole-controller reset is reported.

// File: rtl/sdcr_pkg.sv
package sdcr_pkg;
  localparam int WORD_W      = 32;
  localparam int ICE_BIT     = 0;
  localparam int ICS_BIT     = 1;
  localparam int CEN_BIT     = 2;
  localparam int DIV_LSB     = 6;
  localparam int DIV_W       = 10;
  localparam int TMO_LSB     = 16;
  localparam int TMO_W       = 4;
  localparam int RST_LSB     = 24;
  localparam int RST_N_CHAN  = 3;
  localparam int CH_ALL      = 0;
  localparam int CH_CMD      = 1;
  localparam int CH_DAT      = 2;
endpackage

// File: rtl/sdcr_clk_stable.sv
module sdcr_clk_stable #(
  parameter int STABLE_CYCLES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ice,
  output logic ics
);
  localparam int CW = $clog2(STABLE_CYCLES + 1);
  localparam logic [CW-1:0] LIM = CW'(STABLE_CYCLES);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!ice) begin
      cnt_d = '0;
    end else if (cnt_q != LIM) begin
      cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign ics = ice && (cnt_q == LIM);

  // R3: the flag never comes up in the same cycle the enable first rises
  a_r3_not_early: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ice) |-> !ics);
endmodule

// File: rtl/sdcr_rst_chan.sv
module sdcr_rst_chan #(
  parameter int HOLD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic act
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD_CYCLES - 1);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (start) begin
      act_d = 1'b1;
      cnt_d = LOAD;
    end else if (act_q) begin
      if (cnt_q == '0) begin
        act_d = 1'b0;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign act = act_q;

  // R9: a requested reset is visible on the very next read
  a_r9_start_visible: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> act);
endmodule

// File: rtl/sdcr_card_clk.sv
module sdcr_card_clk #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_in,
  output logic             card_clk
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             tog_q, tog_d;
  logic             bypass;

  always_comb begin
    div_d = div_q;
    cnt_d = cnt_q;
    tog_d = tog_q;
    if (!en) begin
      div_d = div_in;
      cnt_d = '0;
      tog_d = 1'b0;
    end else begin
      tog_d = (cnt_q < (div_q >> 1));
      cnt_d = (cnt_q == div_q - ONE) ? '0 : cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
      tog_q <= 1'b0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
      tog_q <= tog_d;
    end
  end

  assign bypass   = (div_q <= ONE);
  assign card_clk = bypass ? (clk & en) : tog_q;

  // R8: a closed gate drives the divided output low on the next edge
  a_r8_gated_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !tog_q);

  // R8: the divisor in use does not move while the gate is open
  a_r8_div_held: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(div_q));
endmodule

// File: rtl/sd_clkrst_ctrl.sv
module sd_clkrst_ctrl
  import sdcr_pkg::*;
#(
  parameter int STABLE_CYCLES = 5,
  parameter int RST_CYCLES    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  input  logic              cmd_busy,
  input  logic              dat_busy,
  output logic [TMO_W-1:0]  data_tmo,
  output logic              card_clk,
  output logic              cmd_rst,
  output logic              dat_rst,
  output logic              rst_busy
);
  logic [1:0] rsync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_q_n = rsync_q[1];

  logic                  ice_q, ice_d;
  logic                  cen_q, cen_d;
  logic [DIV_W-1:0]      div_q, div_d;
  logic [TMO_W-1:0]      tmo_q, tmo_d;
  logic                  ics;
  logic [RST_N_CHAN-1:0] rst_act;
  logic                  all_start;
  logic                  lock_div;

  sdcr_clk_stable #(.STABLE_CYCLES(STABLE_CYCLES)) u_stable (
    .clk   (clk),
    .rst_n (rst_q_n),
    .ice   (ice_q),
    .ics   (ics)
  );

  for (genvar g = 0; g < RST_N_CHAN; g++) begin : g_rst
    sdcr_rst_chan #(.HOLD_CYCLES(RST_CYCLES)) u_chan (
      .clk   (clk),
      .rst_n (rst_q_n),
      .start (wr_en && wr_data[RST_LSB + g]),
      .act   (rst_act[g])
    );
  end

  sdcr_card_clk #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .en       (cen_q),
    .div_in   (div_q),
    .card_clk (card_clk)
  );

  assign all_start = wr_en && wr_data[RST_LSB + CH_ALL];
  assign lock_div  = cen_q || cmd_busy || dat_busy;

  always_comb begin
    ice_d = ice_q;
    cen_d = cen_q;
    div_d = div_q;
    tmo_d = tmo_q;
    if (wr_en) begin
      tmo_d = wr_data[TMO_LSB +: TMO_W];
      ice_d = wr_data[ICE_BIT];
      cen_d = wr_data[CEN_BIT] && wr_data[ICE_BIT] && ics;
      if (!lock_div) begin
        div_d = wr_data[DIV_LSB +: DIV_W];
      end
    end
    if (all_start || rst_act[CH_ALL]) begin
      ice_d = 1'b0;
      cen_d = 1'b0;
      div_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ice_q <= 1'b0;
      cen_q <= 1'b0;
      div_q <= '0;
      tmo_q <= '0;
    end else begin
      ice_q <= ice_d;
      cen_q <= cen_d;
      div_q <= div_d;
      tmo_q <= tmo_d;
    end
  end

  always_comb begin
    rd_data                          = '0;
    rd_data[ICE_BIT]                 = ice_q;
    rd_data[ICS_BIT]                 = ics;
    rd_data[CEN_BIT]                 = cen_q;
    rd_data[DIV_LSB +: DIV_W]        = div_q;
    rd_data[TMO_LSB +: TMO_W]        = tmo_q;
    rd_data[RST_LSB +: RST_N_CHAN]   = rst_act;
  end

  assign data_tmo = tmo_q;
  assign cmd_rst  = rst_act[CH_ALL] | rst_act[CH_CMD];
  assign dat_rst  = rst_act[CH_ALL] | rst_act[CH_DAT];
  assign rst_busy = |rst_act;

  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data[31:27], wr_data[23:20], wr_data[5:3], wr_data[ICS_BIT]};

  // R4: an open gate always sits on a settled internal clock
  a_r4_gate_needs_stable: assert property (@(posedge clk) disable iff (!rst_q_n)
    cen_q |-> ics);

  // R5: divisor frozen while the gate is open
  a_r5_div_frozen_open: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cen_q && !all_start) |=> $stable(div_q));

  // R5: divisor frozen while a line is busy
  a_r5_div_frozen_busy: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((cmd_busy || dat_busy) && !all_start) |=> $stable(div_q));

  // R10: a whole-controller reset returns enable, gate and divisor to zero
  a_r10_all_clears: assert property (@(posedge clk) disable iff (!rst_q_n)
    all_start |=> (!ice_q && !cen_q && (div_q == '0)));
endmodule

// File: tb/sim_sd_clkrst_ctrl.sv
module sim_sd_clkrst_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int STABLE     = 5;
  localparam int RSTC       = 4;
  localparam int MAX_DIV    = 12;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        cmd_busy;
  logic        dat_busy;
  logic [3:0]  data_tmo;
  logic        card_clk;
  logic        cmd_rst;
  logic        dat_rst;
  logic        rst_busy;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  sd_clkrst_ctrl #(.STABLE_CYCLES(STABLE), .RST_CYCLES(RSTC)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .cmd_busy(cmd_busy), .dat_busy(dat_busy), .data_tmo(data_tmo), .card_clk(card_clk),
    .cmd_rst(cmd_rst), .dat_rst(dat_rst), .rst_busy(rst_busy)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  function automatic logic [31:0] word(input bit ice, input bit cen, input int dv, input int tmo);
    logic [31:0] w;
    w = '0;
    w[0] = ice;
    w[2] = cen;
    w[15:6] = 10'(dv);
    w[19:16] = 4'(tmo);
    return w;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; cmd_busy = 1'b0; dat_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1", "rd_data", rd_data, 32'h0);
    chk("R1", "card_clk", {31'b0, card_clk}, 32'h0);
    chk("R1", "resets", {29'b0, cmd_rst, dat_rst, rst_busy}, 32'h0);
    chk("R1", "data_tmo", {28'b0, data_tmo}, 32'h0);

    // R2 field map, unused bits and read-only flag
    wr(word(0, 0, 'h2A5, 'hE) | 32'hF8F0_003A);
    chk("R2", "field map", rd_data, word(0, 0, 'h2A5, 'hE));
    chk("R2", "data_tmo", {28'b0, data_tmo}, 32'hE);

    // R5 busy lockout
    cmd_busy = 1'b1;
    wr(word(0, 0, 5, 'hE));
    cmd_busy = 1'b0;
    chk("R5", "div under cmd_busy", {22'b0, rd_data[15:6]}, 32'h2A5);
    dat_busy = 1'b1;
    wr(word(0, 0, 5, 'hE));
    dat_busy = 1'b0;
    chk("R5", "div under dat_busy", {22'b0, rd_data[15:6]}, 32'h2A5);
    wr(word(0, 0, 5, 'hE));
    chk("R5", "div when idle", {22'b0, rd_data[15:6]}, 32'h5);

    // R3/R4 stable handshake and early gate attempt
    wr(word(1, 1, 5, 0));
    chk("R4", "gate before stable", {31'b0, rd_data[2]}, 32'h0);
    chk("R3", "flag at write", {31'b0, rd_data[1]}, 32'h0);
    for (int m = 1; m <= STABLE; m++) begin
      @(negedge clk);
      chk("R3", $sformatf("flag after %0d edges", m), {31'b0, rd_data[1]}, {31'b0, m >= STABLE});
    end
    wr(word(1, 1, 5, 0));
    chk("R4", "gate after stable", {31'b0, rd_data[2]}, 32'h1);
    wr(word(1, 1, 7, 0));
    chk("R5", "div while gate open", {22'b0, rd_data[15:6]}, 32'h5);
    wr(word(0, 1, 7, 0));
    chk("R3", "flag drops with enable", {29'b0, rd_data[2:0]}, 32'h0);

    // R6/R8 divider sweep
    wr(word(1, 0, 0, 0));
    repeat (STABLE) @(negedge clk);
    for (int n = 2; n <= MAX_DIV; n++) begin
      int bad;
      wr(word(1, 0, n, 0));
      wr(word(1, 1, n, 0));
      bad = 0;
      for (int j = 0; j < 3 * n; j++) begin
        @(negedge clk);
        if (card_clk !== ((j % n) < (n / 2))) begin
          bad++;
          chk("R6", $sformatf("div %0d sample %0d", n, j), {31'b0, card_clk}, {31'b0, (j % n) < (n / 2)});
        end
      end
      if (bad == 0) chk("R6", $sformatf("div %0d pattern", n), 32'h0, 32'h0);
      wr(word(1, 0, n, 0));
      @(negedge clk);
      chk("R8", $sformatf("low after gate off div %0d", n), {31'b0, card_clk}, 32'h0);
      repeat (n) @(negedge clk);
      chk("R8", $sformatf("stays low div %0d", n), {31'b0, card_clk}, 32'h0);
    end

    // R7 bypass for divisor 0 and 1
    for (int n = 0; n <= 1; n++) begin
      wr(word(1, 0, n, 0));
      wr(word(1, 1, n, 0));
      for (int j = 0; j < 3; j++) begin
        @(posedge clk); #1;
        chk("R7", $sformatf("div %0d high phase", n), {31'b0, card_clk}, 32'h1);
        @(negedge clk); #1;
        chk("R7", $sformatf("div %0d low phase", n), {31'b0, card_clk}, 32'h0);
      end
      wr(word(1, 0, n, 0));
    end

    // R9/R11 command and data path resets
    for (int ch = 0; ch < 2; ch++) begin
      logic [31:0] rb;
      rb = 32'h1 << (25 + ch);
      wr(rb);
      for (int m = 0; m <= RSTC; m++) begin
        if (m > 0) @(negedge clk);
        chk("R9", $sformatf("bit %0d read %0d", 25 + ch, m), rd_data, (m < RSTC) ? rb : 32'h0);
        chk("R9", $sformatf("outputs ch %0d read %0d", ch, m), {30'b0, cmd_rst, dat_rst},
            (m < RSTC) ? ((ch == 0) ? 32'h2 : 32'h1) : 32'h0);
        chk("R11", $sformatf("busy ch %0d read %0d", ch, m), {31'b0, rst_busy}, {31'b0, m < RSTC});
      end
    end

    // R10 whole-controller reset
    wr(word(1, 0, 3, 'hE));
    repeat (STABLE) @(negedge clk);
    wr(word(1, 1, 3, 'hE));
    chk("R10", "setup gate", {31'b0, rd_data[2]}, 32'h1);
    wr(word(1, 1, 9, 'hE) | (32'h1 << 24));
    for (int m = 0; m <= RSTC; m++) begin
      if (m > 0) @(negedge clk);
      chk("R10", $sformatf("word read %0d", m), rd_data,
          word(0, 0, 0, 'hE) | ((m < RSTC) ? (32'h1 << 24) : 32'h0));
      chk("R10", $sformatf("both resets read %0d", m), {30'b0, cmd_rst, dat_rst},
          (m < RSTC) ? 32'h3 : 32'h0);
      chk("R11", $sformatf("busy all read %0d", m), {31'b0, rst_busy}, {31'b0, m < RSTC});
    end
    chk("R10", "card clock low", {31'b0, card_clk}, 32'h0);
    wr(32'h1 << 24);
    wr(word(1, 0, 4, 0));
    chk("R10", "enable ignored during reset", {22'b0, rd_data[15:6], 5'b0, rd_data[0]}, 32'h0);
    chk("R10", "still in reset", {31'b0, rd_data[24]}, 32'h1);
    repeat (RSTC) @(negedge clk);
    chk("R11", "busy clear", {31'b0, rst_busy}, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule